// File: doc/BRIEF.md
# Two-Level Interrupt Status and Enable Register Bank

This block gathers interrupt requests for one peripheral and presents them as a single outgoing interrupt line. It has two tiers. The core tier holds a latched status word and an enable word for up to 32 core sources. Any enabled, active core status bit is folded into one bit of the device tier. The device tier combines three kinds of bit: a latched internal error bit, that folded core bit, and live levels from other sources. On top of these it keeps a device enable word, a pending word, a priority-resolved identifier and a single global gate.

Software reaches every register through a single-cycle read/write port. The address is a byte offset and read data is combinational. Latched status bits set on the rising edge of their hardware source. Software flips them by writing ones, which lets the same write either raise a software interrupt or acknowledge one. A keyed write to the reset word clears the whole bank and gives a one-cycle reset pulse to the neighbouring logic.

Top module: `irq_hier_bank`

## Requirements
- R1: After `rst_n` is released, every mapped register reads 0, the identifier (offset 24) reads 128, and `irq_out` and `soft_rst_out` are 0.
- R2: Writing exactly 0x0000000A to offset 64 sets every register to 0 at that clock edge and drives `soft_rst_out` high for the following cycle. Writing any other value to offset 64 has no effect. Offset 64 reads 0.
- R3: The global gate lives at offset 28, bit 31, and reads back as 0x80000000 or 0. Writing 0 to it leaves both enable words unchanged.
- R4: The core status word (offset 32) inverts every bit written as 1 and keeps every bit written as 0.
- R5: A core status bit sets on a rising edge of its `ip_src` bit. If that edge arrives in the same cycle as a write that would invert the bit, the bit ends up set.
- R6: The core enable word (offset 40) is read/write. Device status bit 1 reads 1 exactly when the core status word ANDed with the core enable word is nonzero.
- R7: In device status (offset 0), bit 0 is a latched error bit. It sets on a rising edge of `dev_src[0]` and inverts on a write of 1 to bit 0, and the hardware set wins over the inversion. Bits 2 to 31 show `dev_src` live. Writes to bits 1 to 31 have no effect.
- R8: The device enable word (offset 8) is read/write. The pending word (offset 4) reads device status AND device enable, and writes to it have no effect.
- R9: The identifier (offset 24) reads the index of the lowest set pending bit (0 to 31), or 128 when no bit is pending.
- R10: `irq_out` is a register. It is 1 in the cycle after one in which the global gate was set and at least one pending bit was set, and 0 otherwise.
- R11: Every other offset in the 7-bit space reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe for the current address |
| reg_addr | input | 7 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| ip_src | input | NUM_IP | Core source levels; a rising edge latches status |
| dev_src | input | 32 | Device source levels; bit 0 is the error edge source, bit 1 is unused, bits 2 to 31 are shown live |
| irq_out | output | 1 | Registered outgoing interrupt |
| soft_rst_out | output | 1 | One-cycle pulse after a keyed reset write |

## Verification
Some properties are checked on every cycle. The latched bits hold their value unless a write or a source edge touches them. A hardware edge always leaves its bit set. The identifier reads 128 exactly when nothing is pending. The outgoing line never rises while the gate is off, and a keyed reset write always clears the enables and pulses the reset output. Other behaviour only the bench's scenarios can show: the exact inversion pattern of status writes, the mix of live and latched device bits, the folded core bit, the priority order across several pending bits, and that unkeyed reset writes and writes to unmapped offsets leave state alone. The bench shows these by comparing every read and every cycle of `irq_out` against its own model.

// File: rtl/irq_hier_pkg.sv
package irq_hier_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned ID_W   = 8;

  localparam logic [ADDR_W-1:0] OFS_DEV_STAT = 7'd0;
  localparam logic [ADDR_W-1:0] OFS_DEV_PEND = 7'd4;
  localparam logic [ADDR_W-1:0] OFS_DEV_EN   = 7'd8;
  localparam logic [ADDR_W-1:0] OFS_ID       = 7'd24;
  localparam logic [ADDR_W-1:0] OFS_GATE     = 7'd28;
  localparam logic [ADDR_W-1:0] OFS_IP_STAT  = 7'd32;
  localparam logic [ADDR_W-1:0] OFS_IP_EN    = 7'd40;
  localparam logic [ADDR_W-1:0] OFS_RESET    = 7'd64;

  localparam logic [WORD_W-1:0] RESET_KEY = 32'h0000_000A;
  localparam logic [ID_W-1:0]   NO_IRQ_ID = 8'd128;
  localparam int unsigned       GATE_BIT  = 31;

  // Next value of a latched status word: invert on written ones, edges win.
  function automatic logic [WORD_W-1:0] latch_next(input logic [WORD_W-1:0] cur,
                                                   input logic [WORD_W-1:0] flip,
                                                   input logic [WORD_W-1:0] rise);
    return (cur ^ flip) | rise;
  endfunction

  // Index of the lowest set bit, or the reserved empty code.
  function automatic logic [ID_W-1:0] lowest_set(input logic [WORD_W-1:0] v);
    logic [ID_W-1:0] r;
    r = NO_IRQ_ID;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (v[i]) r = ID_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_ip_level.sv
module irq_ip_level
  import irq_hier_pkg::*;
#(
  parameter int unsigned NUM_IP = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_stat,
  input  logic              wr_en,
  input  logic [NUM_IP-1:0] wdata,
  input  logic [NUM_IP-1:0] src,
  output logic [NUM_IP-1:0] stat_o,
  output logic [NUM_IP-1:0] en_o,
  output logic              agg_o
);
  logic [NUM_IP-1:0] stat_q, en_q, src_q, rise, flip;
  logic [WORD_W-1:0] stat_w, flip_w, rise_w, next_w;

  assign rise   = src & ~src_q;
  assign flip   = wr_stat ? wdata : '0;
  assign stat_w = WORD_W'(stat_q);
  assign flip_w = WORD_W'(flip);
  assign rise_w = WORD_W'(rise);
  assign next_w = latch_next(stat_w, flip_w, rise_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else if (clr) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= next_w[NUM_IP-1:0];
      if (wr_en) en_q <= wdata;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign agg_o  = |(stat_q & en_q);

  // R4: status moves only on a write or a source edge
  a_r4_stat_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !wr_stat && rise == '0) |=> $stable(stat_q));
  // R5: a hardware edge always leaves its bit set
  a_r5_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && rise != '0) |=> ((stat_q & $past(rise)) == $past(rise)));
endmodule

// File: rtl/irq_dev_level.sv
module irq_dev_level
  import irq_hier_pkg::*;
#(
  parameter int unsigned IP_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_stat,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] live,
  input  logic              ip_agg,
  output logic [WORD_W-1:0] stat_o,
  output logic [WORD_W-1:0] en_o,
  output logic [WORD_W-1:0] pend_o
);
  logic              err_q, err_src_q, err_rise, err_next;
  logic [WORD_W-1:0] en_q, err_vec;

  assign err_rise = live[0] & ~err_src_q;
  assign err_vec  = latch_next(WORD_W'(err_q), WORD_W'(wr_stat & wdata[0]), WORD_W'(err_rise));
  assign err_next = err_vec[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_src_q <= 1'b0;
    else        err_src_q <= live[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      en_q  <= '0;
    end else if (clr) begin
      err_q <= 1'b0;
      en_q  <= '0;
    end else begin
      err_q <= err_next;
      if (wr_en) en_q <= wdata;
    end
  end

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    if (i == 0) begin : g_err
      assign stat_o[i] = err_q;
    end else if (i == IP_BIT) begin : g_ip
      assign stat_o[i] = ip_agg;
    end else begin : g_live
      assign stat_o[i] = live[i];
    end
  end

  assign en_o   = en_q;
  assign pend_o = stat_o & en_q;

  // R7: latched error bit holds without a write of bit 0 or an edge
  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(wr_stat && wdata[0]) && !err_rise) |=> $stable(err_q));
  // R7: error edge always leaves the bit set
  a_r7_err_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && err_rise) |=> err_q);
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve
  import irq_hier_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] pend_i,
  output logic [ID_W-1:0]   id_o
);
  assign id_o = lowest_set(pend_i);

  // R9: empty code exactly when nothing is pending
  a_r9_empty_code: assert property (@(posedge clk) disable iff (!rst_n)
    (id_o == NO_IRQ_ID) == (pend_i == '0));
  // R9: a reported index points at a pending bit
  a_r9_index_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (id_o != NO_IRQ_ID) |-> pend_i[id_o[4:0]]);
endmodule

// File: rtl/irq_hier_bank.sv
module irq_hier_bank
  import irq_hier_pkg::*;
#(
  parameter int unsigned NUM_IP = 32,
  parameter int unsigned IP_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [6:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_IP-1:0] ip_src,
  input  logic [31:0]       dev_src,
  output logic              irq_out,
  output logic              soft_rst_out
);
  logic wr_dev_stat, wr_dev_en, wr_gate, wr_ip_stat, wr_ip_en, reset_go;
  logic gate_q, irq_q, soft_q, ip_agg;
  logic [NUM_IP-1:0] ip_stat, ip_en;
  logic [WORD_W-1:0] dev_stat, dev_en, dev_pend;
  logic [ID_W-1:0]   irq_id;

  assign wr_dev_stat = reg_we && (reg_addr == OFS_DEV_STAT);
  assign wr_dev_en   = reg_we && (reg_addr == OFS_DEV_EN);
  assign wr_gate     = reg_we && (reg_addr == OFS_GATE);
  assign wr_ip_stat  = reg_we && (reg_addr == OFS_IP_STAT);
  assign wr_ip_en    = reg_we && (reg_addr == OFS_IP_EN);
  assign reset_go    = reg_we && (reg_addr == OFS_RESET) && (reg_wdata == RESET_KEY);

  irq_ip_level #(.NUM_IP(NUM_IP)) u_ip (
    .clk(clk), .rst_n(rst_n), .clr(reset_go),
    .wr_stat(wr_ip_stat), .wr_en(wr_ip_en), .wdata(reg_wdata[NUM_IP-1:0]),
    .src(ip_src), .stat_o(ip_stat), .en_o(ip_en), .agg_o(ip_agg)
  );

  irq_dev_level #(.IP_BIT(IP_BIT)) u_dev (
    .clk(clk), .rst_n(rst_n), .clr(reset_go),
    .wr_stat(wr_dev_stat), .wr_en(wr_dev_en), .wdata(reg_wdata),
    .live(dev_src), .ip_agg(ip_agg),
    .stat_o(dev_stat), .en_o(dev_en), .pend_o(dev_pend)
  );

  irq_prio_resolve u_prio (
    .clk(clk), .rst_n(rst_n), .pend_i(dev_pend), .id_o(irq_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      irq_q  <= 1'b0;
      soft_q <= 1'b0;
    end else begin
      soft_q <= reset_go;
      if (reset_go) begin
        gate_q <= 1'b0;
        irq_q  <= 1'b0;
      end else begin
        if (wr_gate) gate_q <= reg_wdata[GATE_BIT];
        irq_q <= gate_q && (dev_pend != '0);
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_DEV_STAT: reg_rdata = dev_stat;
      OFS_DEV_PEND: reg_rdata = dev_pend;
      OFS_DEV_EN:   reg_rdata = dev_en;
      OFS_ID:       reg_rdata = WORD_W'(irq_id);
      OFS_GATE:     reg_rdata = {gate_q, 31'b0};
      OFS_IP_STAT:  reg_rdata = WORD_W'(ip_stat);
      OFS_IP_EN:    reg_rdata = WORD_W'(ip_en);
      default:      reg_rdata = '0;
    endcase
  end

  assign irq_out      = irq_q;
  assign soft_rst_out = soft_q;

  // R10: the line never rises unless the gate was set a cycle earlier
  a_r10_gate_needed: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(gate_q));
  // R2: keyed reset write clears enables and pulses the reset output
  a_r2_key_clears: assert property (@(posedge clk) disable iff (!rst_n)
    reset_go |=> (soft_rst_out && !gate_q && dev_en == '0 && ip_en == '0));
  // R3: gate changes only when its word is written or the bank is reset
  a_r3_gate_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_gate && !reset_go) |=> $stable(gate_q));
endmodule

// File: tb/irq_hier_bank_test.sv
`timescale 1ns/1ps
module irq_hier_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] ip_src = '0;
  logic [31:0] dev_src = '0;
  logic        irq_out, soft_rst_out;

  int errors = 0;
  int checks = 0;

  // model state
  logic [31:0] m_ipst, m_ipen, m_den, m_ipprev;
  logic        m_err, m_errprev, m_gate, m_irq, m_soft;

  always #5 clk = ~clk;

  irq_hier_bank uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ip_src(ip_src),
    .dev_src(dev_src), .irq_out(irq_out), .soft_rst_out(soft_rst_out)
  );

  function automatic logic [31:0] m_dstat();
    logic [31:0] s;
    s = dev_src;
    s[0] = m_err;
    s[1] = ((m_ipst & m_ipen) != 0);
    return s;
  endfunction

  function automatic logic [31:0] m_id(input logic [31:0] p);
    for (int i = 0; i < 32; i++) if (p[i]) return 32'(i);
    return 32'd128;
  endfunction

  function automatic logic [31:0] m_read(input logic [6:0] a);
    case (a)
      7'd0:  return m_dstat();
      7'd4:  return m_dstat() & m_den;
      7'd8:  return m_den;
      7'd24: return m_id(m_dstat() & m_den);
      7'd28: return m_gate ? 32'h8000_0000 : 32'h0;
      7'd32: return m_ipst;
      7'd40: return m_ipen;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [6:0] a);
    case (a)
      7'd0:  return "R7";
      7'd4:  return "R8";
      7'd8:  return "R8";
      7'd24: return "R9";
      7'd28: return "R3";
      7'd32: return "R4/R5";
      7'd40: return "R6";
      7'd64: return "R2";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive, check read, compute model next, clock, check outputs.
  task automatic cyc(input logic we, input logic [6:0] a, input logic [31:0] wd,
                     input logic [31:0] ips, input logic [31:0] dvs, input bit rd_chk);
    logic [31:0] n_ipst, n_ipen, n_den;
    logic        n_err, n_gate, n_irq, key;
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = wd; ip_src = ips; dev_src = dvs;
    #1;
    if (rd_chk) chk(req_of(a), reg_rdata, m_read(a));
    key    = we && a == 7'd64 && wd == 32'hA;
    n_ipst = (m_ipst ^ ((we && a == 7'd32) ? wd : 32'h0)) | (ips & ~m_ipprev);
    n_ipen = (we && a == 7'd40) ? wd : m_ipen;
    n_den  = (we && a == 7'd8) ? wd : m_den;
    n_err  = (m_err ^ (we && a == 7'd0 && wd[0])) | (dvs[0] & ~m_errprev);
    n_gate = (we && a == 7'd28) ? wd[31] : m_gate;
    n_irq  = m_gate && ((m_dstat() & m_den) != 0);
    @(posedge clk);
    #1;
    if (key) begin
      m_ipst = 0; m_ipen = 0; m_den = 0; m_err = 0; m_gate = 0; m_irq = 0;
    end else begin
      m_ipst = n_ipst; m_ipen = n_ipen; m_den = n_den; m_err = n_err;
      m_gate = n_gate; m_irq = n_irq;
    end
    m_soft = key; m_ipprev = ips; m_errprev = dvs[0];
    chk("R10", 32'(irq_out), 32'(m_irq));
    chk("R2", 32'(soft_rst_out), 32'(m_soft));
  endtask

  task automatic rd(input logic [6:0] a);
    cyc(1'b0, a, 32'h0, ip_src, dev_src, 1'b1);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, ip_src, dev_src, 1'b0);
  endtask

  initial begin
    #(10 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    m_ipst = 0; m_ipen = 0; m_den = 0; m_ipprev = 0;
    m_err = 0; m_errprev = 0; m_gate = 0; m_irq = 0; m_soft = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    #1;
    chk("R1", reg_rdata, 32'h0);
    reg_addr = 7'd24; #1;
    chk("R1", reg_rdata, 32'd128);
    chk("R1", 32'(irq_out), 32'h0);
    chk("R1", 32'(soft_rst_out), 32'h0);

    // R4: write-one inverts
    wr(7'd32, 32'h0000_00F0); rd(7'd32);
    wr(7'd32, 32'h0000_0030); rd(7'd32);
    chk("R4", m_ipst, 32'h0000_00C0);
    // R6: fold into device bit 1
    wr(7'd40, 32'h0000_0040); rd(7'd0);
    wr(7'd8, 32'h0000_0002); rd(7'd4); rd(7'd24);
    wr(7'd28, 32'h8000_0000); rd(7'd28);
    rd(7'd0); rd(7'd0);
    chk("R10", 32'(irq_out), 32'h1);
    // R3: gate off keeps enables
    wr(7'd28, 32'h0); rd(7'd8); rd(7'd40); rd(7'd0);
    chk("R3", 32'(irq_out), 32'h0);
    // R5: edge and invert in the same cycle -> set
    cyc(1'b1, 7'd32, 32'h0000_0001, 32'h0000_0001, 32'h0, 1'b0);
    rd(7'd32);
    chk("R5", m_ipst & 32'h1, 32'h1);
    // R7: error edge, live bits, writes to live bits ignored
    cyc(1'b0, 7'd0, 32'h0, 32'h0, 32'h0000_0001, 1'b1);
    cyc(1'b1, 7'd0, 32'hFFFF_FFFE, 32'h0, 32'hA000_0004, 1'b0);
    rd(7'd0);
    wr(7'd0, 32'h1); rd(7'd0);
    // R9: priority among several pending bits
    wr(7'd8, 32'hFFFF_FFFF);
    cyc(1'b0, 7'd24, 32'h0, 32'h0, 32'h0010_1000, 1'b1);
    rd(7'd24);
    // R8: pending ignores writes
    wr(7'd4, 32'hFFFF_FFFF); rd(7'd4);
    // R11: unmapped offsets
    wr(7'd12, 32'hFFFF_FFFF); rd(7'd12); rd(7'd100); rd(7'd8);
    // R2: unkeyed write ignored, keyed write clears
    wr(7'd28, 32'h8000_0000);
    wr(7'd64, 32'h0000_000B); rd(7'd64); rd(7'd28);
    wr(7'd64, 32'h0000_000A); rd(7'd8); rd(7'd28); rd(7'd40); rd(7'd24);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [6:0]  offs[11];
      logic [6:0]  a;
      logic [31:0] d;
      offs = '{7'd0, 7'd4, 7'd8, 7'd24, 7'd28, 7'd32, 7'd40, 7'd64, 7'd12, 7'd100, 7'd2};
      a = offs[$urandom_range(0, 10)];
      d = $urandom() & $urandom();
      if (a == 7'd64 && $urandom_range(0, 5) == 0) d = 32'hA;
      if (a == 7'd28) d = {$urandom_range(0, 1) == 1, 31'h0};
      cyc($urandom_range(0, 2) == 0, a, d,
          $urandom() & $urandom() & $urandom(),
          $urandom() & $urandom() & $urandom(), 1'b1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule